// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel ports, A and B, that share one set of pins in the real system. Each direction has a storage register and a capture strobe of its own. The A-to-B register keeps words taken from port A. The B-to-A register keeps words taken from port B. Each pin is modelled here as a separate input, output and output-enable, rather than as a true tristate pin.

Two control inputs pick which port is driven, if either. The first is an active-low output enable. The second is a direction input. For each direction, a select input picks what the driven port carries: the live word arriving on the opposite port, or the stored register word.

Capture never depends on the drive controls. With both ports isolated, the block can still store an A word in one register and a B word in the other. The capture strobes are synchronous to the single system clock. Each strobe is edge-detected inside the block, so a strobe held high stores only one word.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On the rising clock edge at which `cap_ab` is first sampled high after being sampled low, the A-to-B register loads `a_in`. The new word is visible on `b_out` (in stored mode) from that edge onward.
- R2: On the rising clock edge at which `cap_ba` is first sampled high after being sampled low, the B-to-A register loads `b_in`. The new word is visible on `a_out` (in stored mode) from that edge onward.
- R3: A strobe held high for several cycles stores only the word present at its first high edge. Later changes of the port data while the strobe stays high leave the register unchanged.
- R4: Captures into both registers take place whatever the values of `oe_n` and `dir`, including isolation mode (`oe_n` = 1).
- R5: While `oe_n` = 1, both `a_oe` and `b_oe` are 0 and both `a_out` and `b_out` are all zeros.
- R6: While `oe_n` = 0 and `dir` = 0, `a_oe` = 1 and `b_oe` = 0 and `b_out` is zero. While `oe_n` = 0 and `dir` = 1, `b_oe` = 1 and `a_oe` = 0 and `a_out` is zero. The enables follow `oe_n` and `dir` in the same cycle.
- R7: While port A is driven and `sel_ba` = 0, `a_out` equals `b_in` in the same cycle.
- R8: While port A is driven and `sel_ba` = 1, `a_out` equals the B-to-A register contents.
- R9: While port B is driven and `sel_ab` = 0, `b_out` equals `a_in` in the same cycle.
- R10: While port B is driven and `sel_ab` = 1, `b_out` equals the A-to-B register contents.
- R11: `a_oe` and `b_oe` are never 1 together.
- R12: A synchronous active-high `rst` clears both registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable for both ports |
| dir | input | 1 | Drive direction: 0 drives port A, 1 drives port B |
| sel_ab | input | 1 | Port B source: 0 live A, 1 stored A-to-B word |
| sel_ba | input | 1 | Port A source: 0 live B, 1 stored B-to-A word |
| cap_ab | input | 1 | Capture strobe for the A-to-B register |
| cap_ba | input | 1 | Capture strobe for the B-to-A register |
| a_in | input | W | Data arriving on port A |
| a_out | output | W | Data driven onto port A (zero when not driven) |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | W | Data arriving on port B |
| b_out | output | W | Data driven onto port B (zero when not driven) |
| b_oe | output | 1 | Port B drive enable |

## Verification
The drive enables, the live paths and the stored-mode multiplexing are combinational, so those results are due in the same cycle as the stimulus. A capture is due at the first rising clock edge that samples its strobe high, and the stored word appears right after that edge. The bench changes inputs just after a falling edge and checks combinational results 1 ns later, well before the next rising edge. It reads a stored word only after the falling edge that follows the capturing edge. A sweep over every combination of the four controls, under several data patterns and register contents, checks each output against a model built from the requirements.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  localparam int LANE_AB   = 0;
  localparam int LANE_BA   = 1;
  localparam int NUM_LANES = 2;

  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic pulse
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign pulse = strobe & ~strobe_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] din,
  input  logic         use_stored,
  input  logic         drive,
  output logic [W-1:0] dout
);
  logic         load;
  logic [W-1:0] held;

  xcvr_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .pulse  (load)
  );

  always_ff @(posedge clk) begin
    if (rst)       held <= '0;
    else if (load) held <= din;
  end

  always_comb begin
    if (!drive)         dout = '0;
    else if (use_stored) dout = held;
    else                dout = din;
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import bus_xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir,
  output logic drv_a,
  output logic drv_b
);
  drive_e mode;

  always_comb begin
    if (oe_n)     mode = DRV_NONE;
    else if (dir) mode = DRV_B;
    else          mode = DRV_A;
  end

  assign drv_a = (mode == DRV_A);
  assign drv_b = (mode == DRV_B);
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bus_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [NUM_LANES-1:0][W-1:0] lane_din;
  logic [NUM_LANES-1:0][W-1:0] lane_dout;
  logic [NUM_LANES-1:0]        lane_stb;
  logic [NUM_LANES-1:0]        lane_sel;
  logic [NUM_LANES-1:0]        lane_drv;
  logic                        drv_a;
  logic                        drv_b;

  xcvr_drive_ctl u_ctl (
    .oe_n  (oe_n),
    .dir   (dir),
    .drv_a (drv_a),
    .drv_b (drv_b)
  );

  // lane AB takes from A and drives B; lane BA takes from B and drives A
  assign lane_din[LANE_AB] = a_in;
  assign lane_stb[LANE_AB] = cap_ab;
  assign lane_sel[LANE_AB] = sel_ab;
  assign lane_drv[LANE_AB] = drv_b;
  assign lane_din[LANE_BA] = b_in;
  assign lane_stb[LANE_BA] = cap_ba;
  assign lane_sel[LANE_BA] = sel_ba;
  assign lane_drv[LANE_BA] = drv_a;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    xcvr_lane #(.W(W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .strobe     (lane_stb[g]),
      .din        (lane_din[g]),
      .use_stored (lane_sel[g]),
      .drive      (lane_drv[g]),
      .dout       (lane_dout[g])
    );
  end

  assign b_out = lane_dout[LANE_AB];
  assign a_out = lane_dout[LANE_BA];
  assign a_oe  = drv_a;
  assign b_oe  = drv_b;
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         cap_ab,
  input logic         cap_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  logic         pab_q, pba_q;
  logic [W-1:0] shadow_ab, shadow_ba;

  always_ff @(posedge clk) begin
    if (rst) begin
      pab_q <= 1'b0; pba_q <= 1'b0;
      shadow_ab <= '0; shadow_ba <= '0;
    end else begin
      pab_q <= cap_ab; pba_q <= cap_ba;
      if (cap_ab && !pab_q) shadow_ab <= a_in;
      if (cap_ba && !pba_q) shadow_ba <= b_in;
    end
  end

  assert_oe_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe));
  assert_isolation_R5: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));
  assert_drive_a_R6: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !dir) |-> (a_oe && !b_oe && b_out == '0));
  assert_drive_b_R6: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir) |-> (b_oe && !a_oe && a_out == '0));
  assert_live_a_R7: assert property (@(posedge clk) disable iff (rst)
    (a_oe && !sel_ba) |-> (a_out == b_in));
  assert_stored_a_R8: assert property (@(posedge clk) disable iff (rst)
    (a_oe && sel_ba) |-> (a_out == shadow_ba));
  assert_live_b_R9: assert property (@(posedge clk) disable iff (rst)
    (b_oe && !sel_ab) |-> (b_out == a_in));
  assert_stored_b_R10: assert property (@(posedge clk) disable iff (rst)
    (b_oe && sel_ab) |-> (b_out == shadow_ab));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (.*);

// File: tb/test_bus_xcvr_reg.sv
`timescale 1ns/1ps
module test_bus_xcvr_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic         cap_ab = 1'b0, cap_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  always #5 clk = ~clk;

  bus_xcvr_reg #(.W(W)) i_bus_xcvr_reg (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba), .a_in(a_in),
    .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // full output check against the model, tagged by the requirement covered
  task automatic chk_all(input string ctx);
    logic ea, eb;
    logic [W-1:0] xa, xb;
    ea = !oe_n && !dir;
    eb = !oe_n && dir;
    xa = ea ? (sel_ba ? m_ba : b_in) : '0;
    xb = eb ? (sel_ab ? m_ab : a_in) : '0;
    chk({ctx, " R11 exclusive"}, {7'd0, a_oe & b_oe}, '0);
    chk({ctx, oe_n ? " R5 a_oe" : " R6 a_oe"}, {7'd0, a_oe}, {7'd0, ea});
    chk({ctx, oe_n ? " R5 b_oe" : " R6 b_oe"}, {7'd0, b_oe}, {7'd0, eb});
    chk({ctx, !ea ? " R5/R6 a_out" : (sel_ba ? " R8 a_out" : " R7 a_out")}, a_out, xa);
    chk({ctx, !eb ? " R5/R6 b_out" : (sel_ab ? " R10 b_out" : " R9 b_out")}, b_out, xb);
  endtask

  task automatic sweep(input string ctx);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      {oe_n, dir, sel_ab, sel_ba} = c[3:0];
      #1 chk_all(ctx);
    end
  endtask

  task automatic pulse(input logic do_ab, input logic do_ba);
    @(negedge clk);
    cap_ab = do_ab; cap_ba = do_ba;
    @(negedge clk);
    if (do_ab) m_ab = a_in;
    if (do_ba) m_ba = b_in;
    cap_ab = 1'b0; cap_ba = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    a_in = 8'h77; b_in = 8'h99;
    cap_ab = 1'b1; cap_ba = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cap_ab = 1'b0; cap_ba = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    // R12: registers zero after reset, read in stored mode
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    #1 chk("R12 ab reg after reset", b_out, 8'h00);
    dir = 1'b0; sel_ba = 1'b1;
    #1 chk("R12 ba reg after reset", a_out, 8'h00);

    // live and drive sweep with several data patterns
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      a_in = 8'(p * 37 + 5); b_in = ~8'(p * 91 + 3);
      sweep("sweep0");
    end

    // R4: capture both while isolated
    @(negedge clk);
    oe_n = 1'b1; a_in = 8'h3C; b_in = 8'hC3;
    pulse(1'b1, 1'b1);
    a_in = 8'h00; b_in = 8'h11;
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    #1 chk("R4 R1 ab captured in isolation", b_out, 8'h3C);
    dir = 1'b0; sel_ba = 1'b1;
    #1 chk("R4 R2 ba captured in isolation", a_out, 8'hC3);

    // R1/R2 capture while driving, one strobe at a time
    a_in = 8'h5E; b_in = 8'hE5;
    pulse(1'b1, 1'b0);
    dir = 1'b1;
    #1 chk("R1 ab capture while driving", b_out, 8'h5E);
    dir = 1'b0;
    #1 chk("R2 ba untouched by ab strobe", a_out, 8'hC3);
    a_in = 8'h21; b_in = 8'h12;
    pulse(1'b0, 1'b1);
    #1 chk("R2 ba capture", a_out, 8'h12);
    dir = 1'b1;
    #1 chk("R1 ab untouched by ba strobe", b_out, 8'h5E);

    // R3: held strobe captures once
    @(negedge clk);
    a_in = 8'hA1; cap_ab = 1'b1;
    @(negedge clk);
    m_ab = 8'hA1;
    for (int k = 0; k < 4; k++) begin
      a_in = 8'(8'hB0 + k);
      @(negedge clk);
    end
    #1 chk("R3 held strobe no recapture", b_out, 8'hA1);
    cap_ab = 1'b0;

    // sweep again with new stored words and patterns
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      a_in = 8'(p * 53 + 17); b_in = 8'(p * 29 + 200);
      sweep("sweep1");
    end

    // R12: reset clears captured words
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; m_ab = '0; m_ba = '0;
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    #1 chk("R12 ab cleared", b_out, 8'h00);
    dir = 1'b0; sel_ba = 1'b1;
    #1 chk("R12 ba cleared", a_out, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule